// File: doc/BRIEF.md
# I2C Bit-Level Timing Generator

This block turns one bus condition at a time into SCL and SDA waveforms: a START from an idle bus, a repeated START, a STOP, one transmitted bit or one received bit. A command sequencer above it presents a request with a valid/acknowledge handshake. The block then steps through a fixed series of timed phases. Every phase lasts a programmable number of system clock cycles, and a programmed count of zero lasts one cycle. Both lines are driven in open-drain fashion: an output at 1 pulls its line low and an output at 0 releases it. The filtered SDA level is read back so that the block can capture received data and detect a lost arbitration.

Between conditions the block parks with SCL held low, or sits idle with both lines released. It reports completion with a one-cycle pulse. The captured SDA level is shown on a bit output. A separate pulse reports that another device won the bus. After a loss the block releases both lines and returns to idle without issuing a STOP. The SCL state machine position is visible as a 3-bit code.

Top module: `i2c_bit_timer`

In the requirements, "eff(x)" means x, or 1 when x is 0. Offsets are counted in clock cycles from the clock edge that accepts a request. Commands are coded on reqCmd as 0 = START, 1 = STOP, 2 = WRITE and 3 = READ.

## Requirements
- R1: After reset both line outputs are 0 (released), sclState is 0, and done, arbLost and reqAck are 0.
- R2: A START accepted in idle pulls SDA low at offset 0. It pulls SCL low at offset eff(tStartHold), with done in the following cycle, and then parks in state 3.
- R3: For a WRITE or READ accepted while parked, SDA keeps its level for eff(tDataHold) cycles and then takes the new value: pulled for a WRITE of 0, released for a WRITE of 1 or a READ. SCL is released after max(tLow, eff(tDataHold)+1) cycles in total.
- R4: During a bit, SCL stays released for max(tHigh, eff(tSample)+1) cycles. It is then pulled low again, and done pulses in the first cycle that SCL is low.
- R5: SDA is captured at the clock edge that ends the eff(tSample)-th cycle after SCL is released. rxBit shows the captured level from that point, including the done cycle.
- R6: A STOP accepted while parked pulls SDA low after eff(tDataHold) cycles and releases SCL at the same total low time as R3. It releases SDA eff(tStopSetup) cycles after SCL is released. After a further eff(tStopHold) cycles it pulses done in state 0 with both lines released.
- R7: A START accepted while parked is a repeated START. SDA is released after eff(tDataHold) cycles, and SCL is released at the same total low time as R3. SDA is pulled low eff(tRestartSetup) cycles later, and SCL is pulled low eff(tStartHold) cycles after that, with done and a return to the parked state.
- R8: If a WRITE of 1 captures SDA low, arbLost pulses in the next cycle with both lines released and state 0. No done is given and no STOP follows. A low SDA in any other cycle of that bit has no effect.
- R9: A request is accepted only in idle (START only) or while parked (any command), and this includes the cycle in which done is high. A STOP, WRITE or READ presented in idle is never acknowledged and leaves the lines untouched.
- R10: done is high for exactly one cycle per completed condition. With all timing inputs at 0, every phase lasts one cycle.
- R11: sclState uses the codes 0 idle, 1 start, 2 low-edge, 3 low, 4 high-edge, 5 high and 6 stop. Code 7 never appears.
- R12: done and arbLost are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | A condition request is presented |
| reqCmd | input | 2 | Requested condition: 0 START, 1 STOP, 2 WRITE, 3 READ |
| reqBit | input | 1 | Bit value for WRITE |
| reqAck | output | 1 | Request accepted at this clock edge |
| tLow | input | 14 | SCL low time in cycles |
| tHigh | input | 14 | SCL high time in cycles |
| tStartHold | input | 10 | SDA fall to SCL fall for a START |
| tRestartSetup | input | 10 | SCL rise to SDA fall for a repeated START |
| tStopSetup | input | 10 | SCL rise to SDA rise for a STOP |
| tStopHold | input | 14 | Bus hold time after the STOP edge |
| tDataHold | input | 10 | SDA hold after the SCL fall |
| tSample | input | 10 | SCL rise to SDA sample point |
| sdaIn | input | 1 | Filtered SDA line level |
| sclLowEn | output | 1 | 1 pulls SCL low |
| sdaLowEn | output | 1 | 1 pulls SDA low |
| done | output | 1 | One-cycle completion pulse |
| rxBit | output | 1 | Most recently captured SDA level |
| arbLost | output | 1 | One-cycle pulse on lost arbitration |
| sclState | output | 3 | Current SCL state code |

## Verification
Two pairs of events can land on one clock edge. A new request can be accepted in the same cycle that done reports the previous bit, and the arbitration check is made in the same cycle as the sample capture. The bench keeps reqValid asserted through whole bits so that the next bit is taken exactly on the done cycle. It checks that no acknowledge appears earlier and that the second bit's timing still counts from that edge. A simulated competing device pulls SDA low in the sample cycle only, or in every cycle except that one. The bench then checks that only the first case yields arbLost with released lines, and that the second case completes normally.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_START     = 3'd1,
    ST_LOW_EDGE  = 3'd2,
    ST_LOW       = 3'd3,
    ST_HIGH_EDGE = 3'd4,
    ST_HIGH      = 3'd5,
    ST_STOP      = 3'd6
  } sclState_e;

  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_STOP  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_READ  = 2'd3
  } busCmd_e;

  // which timing value the phase counter is loaded with
  typedef enum logic [2:0] {
    LEN_START_HOLD,
    LEN_DATA_HOLD,
    LEN_LOW_REST,
    LEN_SAMPLE,
    LEN_HIGH_REST,
    LEN_RESTART_SETUP,
    LEN_STOP_SETUP,
    LEN_STOP_HOLD
  } lenSel_e;

  typedef struct packed {
    logic    load;
    lenSel_e lenSel;
    logic    sclPull;
    logic    sclRelease;
    logic    sdaPull;
    logic    sdaRelease;
    logic    sample;
    logic    flagDone;
    logic    flagArb;
  } strobe_t;

endpackage

// File: rtl/i2c_bit_dp.sv
module i2c_bit_dp
  import i2c_bit_pkg::*;
#(
  parameter int LONG_W  = 14,
  parameter int SHORT_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [LONG_W-1:0]  tLow,
  input  logic [LONG_W-1:0]  tHigh,
  input  logic [LONG_W-1:0]  tStopHold,
  input  logic [SHORT_W-1:0] tStartHold,
  input  logic [SHORT_W-1:0] tRestartSetup,
  input  logic [SHORT_W-1:0] tStopSetup,
  input  logic [SHORT_W-1:0] tDataHold,
  input  logic [SHORT_W-1:0] tSample,
  input  logic               sdaIn,
  output logic               lastCycle,
  output logic               sclLowEn,
  output logic               sdaLowEn,
  output logic               rxBit,
  output logic               done,
  output logic               arbLost
);

  localparam logic [LONG_W-1:0] ONE = LONG_W'(1);

  function automatic logic [LONG_W-1:0] atLeastOne(input logic [LONG_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  logic [LONG_W-1:0] holdEff, sampleEff, lowRest, highRest, loadVal, cnt;

  // hold and sample windows are carved out of the low and high times
  assign holdEff   = atLeastOne(LONG_W'(tDataHold));
  assign sampleEff = atLeastOne(LONG_W'(tSample));
  assign lowRest   = (tLow  > holdEff)   ? tLow  - holdEff   : ONE;
  assign highRest  = (tHigh > sampleEff) ? tHigh - sampleEff : ONE;

  always_comb begin
    case (stb.lenSel)
      LEN_START_HOLD:    loadVal = atLeastOne(LONG_W'(tStartHold));
      LEN_DATA_HOLD:     loadVal = holdEff;
      LEN_LOW_REST:      loadVal = lowRest;
      LEN_SAMPLE:        loadVal = sampleEff;
      LEN_HIGH_REST:     loadVal = highRest;
      LEN_RESTART_SETUP: loadVal = atLeastOne(LONG_W'(tRestartSetup));
      LEN_STOP_SETUP:    loadVal = atLeastOne(LONG_W'(tStopSetup));
      default:           loadVal = atLeastOne(tStopHold);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= ONE;
    else if (stb.load)     cnt <= loadVal;
    else if (cnt > ONE)    cnt <= cnt - ONE;
  end

  assign lastCycle = (cnt == ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclLowEn <= 1'b0;
      sdaLowEn <= 1'b0;
      rxBit    <= 1'b0;
      done     <= 1'b0;
      arbLost  <= 1'b0;
    end else begin
      if (stb.sclPull)         sclLowEn <= 1'b1;
      else if (stb.sclRelease) sclLowEn <= 1'b0;
      if (stb.sdaPull)         sdaLowEn <= 1'b1;
      else if (stb.sdaRelease) sdaLowEn <= 1'b0;
      if (stb.sample)          rxBit    <= sdaIn;
      done    <= stb.flagDone;
      arbLost <= stb.flagArb;
    end
  end

endmodule

// File: rtl/i2c_bit_ctrl.sv
module i2c_bit_ctrl
  import i2c_bit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqCmd,
  input  logic       reqBit,
  input  logic       lastCycle,
  input  logic       sdaIn,
  output logic       reqAck,
  output sclState_e  state,
  output strobe_t    stb
);

  sclState_e nextState;
  logic      parked, parkedNext;
  busCmd_e   cmdQ;
  logic      bitQ;
  logic      isBit;

  assign isBit = (cmdQ == CMD_WRITE) || (cmdQ == CMD_READ);

  always_comb begin
    stb        = '0;
    nextState  = state;
    parkedNext = parked;
    reqAck     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid && (reqCmd == CMD_START)) begin
          reqAck      = 1'b1;
          nextState   = ST_START;
          stb.load    = 1'b1;
          stb.lenSel  = LEN_START_HOLD;
          stb.sdaPull = 1'b1;
        end
      end
      ST_START: begin
        if (lastCycle) begin
          stb.sclPull  = 1'b1;
          stb.flagDone = 1'b1;
          nextState    = ST_LOW;
          parkedNext   = 1'b1;
        end
      end
      ST_LOW: begin
        if (parked) begin
          if (reqValid) begin
            reqAck     = 1'b1;
            parkedNext = 1'b0;
            nextState  = ST_LOW_EDGE;
            stb.load   = 1'b1;
            stb.lenSel = LEN_DATA_HOLD;
          end
        end else if (lastCycle) begin
          stb.sclRelease = 1'b1;
          stb.load       = 1'b1;
          nextState      = isBit ? ST_HIGH_EDGE : ST_HIGH;
          stb.lenSel     = isBit ? LEN_SAMPLE :
                           (cmdQ == CMD_START) ? LEN_RESTART_SETUP : LEN_STOP_SETUP;
        end
      end
      ST_LOW_EDGE: begin
        if (lastCycle) begin
          nextState  = ST_LOW;
          stb.load   = 1'b1;
          stb.lenSel = LEN_LOW_REST;
          if ((cmdQ == CMD_STOP) || ((cmdQ == CMD_WRITE) && !bitQ)) stb.sdaPull = 1'b1;
          else stb.sdaRelease = 1'b1;
        end
      end
      ST_HIGH_EDGE: begin
        if (lastCycle) begin
          stb.sample = 1'b1;
          if ((cmdQ == CMD_WRITE) && bitQ && !sdaIn) begin
            stb.flagArb    = 1'b1;
            stb.sdaRelease = 1'b1;
            nextState      = ST_IDLE;
          end else begin
            nextState  = ST_HIGH;
            stb.load   = 1'b1;
            stb.lenSel = LEN_HIGH_REST;
          end
        end
      end
      ST_HIGH: begin
        if (lastCycle) begin
          if (isBit) begin
            stb.sclPull  = 1'b1;
            stb.flagDone = 1'b1;
            nextState    = ST_LOW;
            parkedNext   = 1'b1;
          end else if (cmdQ == CMD_START) begin
            nextState   = ST_START;
            stb.load    = 1'b1;
            stb.lenSel  = LEN_START_HOLD;
            stb.sdaPull = 1'b1;
          end else begin
            nextState      = ST_STOP;
            stb.load       = 1'b1;
            stb.lenSel     = LEN_STOP_HOLD;
            stb.sdaRelease = 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (lastCycle) begin
          stb.flagDone = 1'b1;
          nextState    = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      parked <= 1'b0;
      cmdQ   <= CMD_START;
      bitQ   <= 1'b0;
    end else begin
      state  <= nextState;
      parked <= parkedNext;
      if (reqAck) begin
        cmdQ <= busCmd_e'(reqCmd);
        bitQ <= reqBit;
      end
    end
  end

endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
  import i2c_bit_pkg::*;
#(
  parameter int LONG_W  = 14,
  parameter int SHORT_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [1:0]         reqCmd,
  input  logic               reqBit,
  output logic               reqAck,
  input  logic [LONG_W-1:0]  tLow,
  input  logic [LONG_W-1:0]  tHigh,
  input  logic [SHORT_W-1:0] tStartHold,
  input  logic [SHORT_W-1:0] tRestartSetup,
  input  logic [SHORT_W-1:0] tStopSetup,
  input  logic [LONG_W-1:0]  tStopHold,
  input  logic [SHORT_W-1:0] tDataHold,
  input  logic [SHORT_W-1:0] tSample,
  input  logic               sdaIn,
  output logic               sclLowEn,
  output logic               sdaLowEn,
  output logic               done,
  output logic               rxBit,
  output logic               arbLost,
  output logic [2:0]         sclState
);

  strobe_t   stb;
  sclState_e state;
  logic      lastCycle;

  i2c_bit_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqCmd    (reqCmd),
    .reqBit    (reqBit),
    .lastCycle (lastCycle),
    .sdaIn     (sdaIn),
    .reqAck    (reqAck),
    .state     (state),
    .stb       (stb)
  );

  i2c_bit_dp #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .tLow          (tLow),
    .tHigh         (tHigh),
    .tStopHold     (tStopHold),
    .tStartHold    (tStartHold),
    .tRestartSetup (tRestartSetup),
    .tStopSetup    (tStopSetup),
    .tDataHold     (tDataHold),
    .tSample       (tSample),
    .sdaIn         (sdaIn),
    .lastCycle     (lastCycle),
    .sclLowEn      (sclLowEn),
    .sdaLowEn      (sdaLowEn),
    .rxBit         (rxBit),
    .done          (done),
    .arbLost       (arbLost)
  );

  assign sclState = state;

endmodule

// File: rtl/i2c_bit_timer_chk.sv
module i2c_bit_timer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqAck,
  input logic [1:0] reqCmd,
  input logic       sclLowEn,
  input logic       sdaLowEn,
  input logic       done,
  input logic       arbLost,
  input logic [2:0] sclState
);

  assert_one_outcome_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(done && arbLost));

  assert_state_code_R11: assert property (@(posedge clk) disable iff (!rstN)
    sclState != 3'd7);

  assert_arb_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    arbLost |-> (!sclLowEn && !sdaLowEn && sclState == 3'd0));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_state_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (sclState == 3'd0 || sclState == 3'd3));

  assert_idle_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqAck && sclState == 3'd0) |-> (reqCmd == 2'd0));

  assert_scl_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclLowEn) |-> (sclState == 3'd4 || sclState == 3'd5));

endmodule

bind i2c_bit_timer i2c_bit_timer_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqAck   (reqAck),
  .reqCmd   (reqCmd),
  .sclLowEn (sclLowEn),
  .sdaLowEn (sdaLowEn),
  .done     (done),
  .arbLost  (arbLost),
  .sclState (sclState)
);

// File: tb/i2c_bit_timer_bench.sv
module i2c_bit_timer_bench;
  import i2c_bit_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqCmd = 2'd0;
  logic reqBit = 1'b0;
  logic reqAck;
  logic [13:0] tLow = 14'd4, tHigh = 14'd4, tStopHold = 14'd3;
  logic [9:0] tStartHold = 10'd2, tRestartSetup = 10'd2, tStopSetup = 10'd2;
  logic [9:0] tDataHold = 10'd1, tSample = 10'd1;
  logic rival = 1'b0;
  logic sdaIn;
  logic sclLowEn, sdaLowEn, done, rxBit, arbLost;
  logic [2:0] sclState;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  logic sclH [256];
  logic sdaH [256];
  logic [2:0] stH [256];

  assign sdaIn = !sdaLowEn && !rival;

  always #4 clk = ~clk;

  i2c_bit_timer u_i2c_bit_timer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCmd(reqCmd), .reqBit(reqBit),
    .reqAck(reqAck), .tLow(tLow), .tHigh(tHigh), .tStartHold(tStartHold),
    .tRestartSetup(tRestartSetup), .tStopSetup(tStopSetup), .tStopHold(tStopHold),
    .tDataHold(tDataHold), .tSample(tSample), .sdaIn(sdaIn), .sclLowEn(sclLowEn),
    .sdaLowEn(sdaLowEn), .done(done), .rxBit(rxBit), .arbLost(arbLost), .sclState(sclState)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog (all requirements): cycles %0d expected below %0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chkEq(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic runCmd(input logic [1:0] cmd, input logic bitV, input logic rAt,
                        input logic rElse, input bit pre, input bit chain);
    int d, doneD, arbD, waitN, ackMid;
    int th, lr, ts, hr, r, sampD, hs, rs, ss, sh;
    logic prevSda, newSda;
    th = eff(tDataHold);
    lr = (tLow > th) ? tLow - th : 1;
    ts = eff(tSample);
    hr = (tHigh > ts) ? tHigh - ts : 1;
    hs = eff(tStartHold);
    rs = eff(tRestartSetup);
    ss = eff(tStopSetup);
    sh = eff(tStopHold);
    r = th + lr + 1;
    sampD = th + lr + ts;
    if (!pre) begin
      @(negedge clk);
      reqValid = 1'b1; reqCmd = cmd; reqBit = bitV;
      #1;
      waitN = 0;
      while (!reqAck && waitN < 20) begin
        @(negedge clk); #1; waitN++;
      end
    end
    chkEq("R9 request accepted", int'(reqAck), 1);
    sclH[0] = sclLowEn; sdaH[0] = sdaLowEn; stH[0] = sclState;
    prevSda = sdaLowEn;
    doneD = -1; arbD = -1; ackMid = 0; d = 1;
    while (d < 250 && doneD < 0 && arbD < 0) begin
      @(negedge clk);
      if (!chain) reqValid = 1'b0;
      rival = (d == sampD) ? rAt : rElse;
      #1;
      sclH[d] = sclLowEn; sdaH[d] = sdaLowEn; stH[d] = sclState;
      if (done) doneD = d;
      if (arbLost) arbD = d;
      if (chain && reqAck && !done) ackMid++;
      d++;
    end
    rival = 1'b0;
    if (cmd == CMD_WRITE || cmd == CMD_READ) begin
      newSda = (cmd == CMD_WRITE) ? !bitV : 1'b0;
      if (cmd == CMD_WRITE && bitV && rAt) begin
        chkEq("R8 arbLost offset", arbD, sampD + 1);
        chkEq("R8 no done on loss", doneD, -1);
        if (arbD < 1) arbD = 1;
        chkEq("R8 lines released", int'({sclH[arbD], sdaH[arbD]}), 0);
        chkEq("R8 state idle", int'(stH[arbD]), 0);
      end else begin
        chkEq("R8 no loss", arbD, -1);
        chkEq("R4 done offset", doneD, r + ts + hr);
        if (doneD < 1) doneD = 1;
        chkEq("R3 SDA held", int'(sdaH[th]), int'(prevSda));
        chkEq("R3 SDA new value", int'(sdaH[th + 1]), int'(newSda));
        chkEq("R3 SCL low before release", int'(sclH[r - 1]), 1);
        chkEq("R3 SCL released", int'(sclH[r]), 0);
        chkEq("R4 SCL high last", int'(sclH[doneD - 1]), 0);
        chkEq("R4 SCL low at done", int'(sclH[doneD]), 1);
        chkEq("R11 low-edge code", int'(stH[1]), 2);
        chkEq("R11 low code", int'(stH[th + 1]), 3);
        chkEq("R11 high-edge code", int'(stH[r]), 4);
        chkEq("R11 high code", int'(stH[r + ts]), 5);
        chkEq("R11 parked code", int'(stH[doneD]), 3);
        chkEq("R5 captured bit", int'(rxBit), int'(!newSda && !rAt));
      end
    end else if (cmd == CMD_STOP) begin
      chkEq("R6 done offset", doneD, r + ss + sh);
      if (doneD < 1) doneD = 1;
      chkEq("R6 SDA pulled", int'(sdaH[th + 1]), 1);
      chkEq("R6 SCL released", int'({sclH[r - 1], sclH[r]}), 2);
      chkEq("R6 SDA before rise", int'(sdaH[r + ss - 1]), 1);
      chkEq("R6 SDA released", int'(sdaH[r + ss]), 0);
      chkEq("R11 stop code", int'(stH[r + ss]), 6);
      chkEq("R6 idle at done", int'(stH[doneD]), 0);
      chkEq("R6 lines released", int'({sclH[doneD], sdaH[doneD]}), 0);
    end else if (stH[0] == 3'd3) begin
      chkEq("R7 done offset", doneD, r + rs + hs);
      if (doneD < 1) doneD = 1;
      chkEq("R7 SDA released", int'(sdaH[th + 1]), 0);
      chkEq("R7 SCL released", int'({sclH[r - 1], sclH[r]}), 2);
      chkEq("R7 SDA before fall", int'(sdaH[r + rs - 1]), 0);
      chkEq("R7 SDA pulled", int'(sdaH[r + rs]), 1);
      chkEq("R11 start code", int'(stH[r + rs]), 1);
      chkEq("R7 SCL low at done", int'({sclH[doneD - 1], sclH[doneD]}), 1);
      chkEq("R7 parked", int'(stH[doneD]), 3);
    end else begin
      chkEq("R2 done offset", doneD, hs + 1);
      if (doneD < 1) doneD = 1;
      chkEq("R2 SDA first", int'({sdaH[1], sclH[1]}), 2);
      chkEq("R11 start code", int'(stH[1]), 1);
      chkEq("R2 SCL before fall", int'(sclH[doneD - 1]), 0);
      chkEq("R2 SCL pulled", int'(sclH[doneD]), 1);
      chkEq("R2 parked", int'(stH[doneD]), 3);
    end
    if (chain) begin
      chkEq("R9 no ack mid-condition", ackMid, 0);
      chkEq("R9 ack in done cycle", int'(reqAck), 1);
    end else if (doneD > 0 || arbD > 0) begin
      @(negedge clk); #1;
      chkEq("R10 done single cycle", int'(done), 0);
      chkEq("R12 no arbLost after", int'(arbLost), 0);
    end
  endtask

  task automatic idleReject(input logic [1:0] cmd);
    @(negedge clk);
    reqValid = 1'b1; reqCmd = cmd;
    for (int i = 0; i < 4; i++) begin
      #1;
      chkEq("R9 idle non-START not acked", int'(reqAck), 0);
      @(negedge clk);
      chkEq("R9 idle lines untouched", int'({sclLowEn, sdaLowEn, sclState}), 0);
    end
    reqValid = 1'b0;
  endtask

  task automatic randTiming();
    tLow = 14'($urandom % 12); tHigh = 14'($urandom % 12);
    tStopHold = 14'($urandom % 10);
    tStartHold = 10'($urandom % 8); tRestartSetup = 10'($urandom % 8);
    tStopSetup = 10'($urandom % 8); tDataHold = 10'($urandom % 6);
    tSample = 10'($urandom % 6);
  endtask

  initial begin
    logic [1:0] c;
    logic b, rA, rE;
    bit pend, ch;
    int nb;
    void'($urandom(32'd11));
    repeat (4) @(negedge clk);
    #1;
    chkEq("R1 reset outputs", int'({sclLowEn, sdaLowEn, done, arbLost, reqAck}), 0);
    chkEq("R1 reset state", int'(sclState), 0);
    rstN = 1'b1;
    idleReject(CMD_STOP);
    idleReject(CMD_WRITE);
    idleReject(CMD_READ);

    for (int round = 0; round < 16; round++) begin
      if (round == 0) begin
        tLow = '0; tHigh = '0; tStopHold = '0; tStartHold = '0;
        tRestartSetup = '0; tStopSetup = '0; tDataHold = '0; tSample = '0;
      end else randTiming();
      runCmd(CMD_START, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      nb = 2 + int'($urandom % 4);
      pend = 1'b0;
      for (int i = 0; i < nb; i++) begin
        if (!pend) begin
          c = ($urandom % 2 == 0) ? CMD_WRITE : CMD_READ;
          b = 1'($urandom % 2);
        end
        rA = (c == CMD_READ) ? 1'($urandom % 2) : 1'b0;
        rE = 1'($urandom % 2);
        ch = (i < nb - 1) && ($urandom % 3 == 0);
        runCmd(c, b, rA, rE, pend, ch);
        pend = ch;
      end
      if ($urandom % 2 == 0) begin
        runCmd(CMD_START, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        runCmd(CMD_READ, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      end
      runCmd(CMD_STOP, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    end

    // directed: glitch outside sample point, then real arbitration loss
    tLow = 14'd6; tHigh = 14'd5; tDataHold = 10'd2; tSample = 10'd2;
    tStartHold = 10'd3; tStopSetup = 10'd2; tStopHold = 14'd3;
    runCmd(CMD_START, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    runCmd(CMD_WRITE, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    runCmd(CMD_WRITE, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #1;
      chkEq("R8 stays idle without STOP", int'({sclLowEn, sdaLowEn, sclState}), 0);
    end
    idleReject(CMD_STOP);
    runCmd(CMD_START, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    runCmd(CMD_STOP, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule